// File: doc/BRIEF.md
# Programmable PC-Triggered Stride Prefetcher

This block holds a small table of software-written prefetch descriptors and watches the stream of committed instruction addresses. A descriptor holds five things: the instruction address that triggers it, the next address to prefetch, a signed step, a divider value and a warm-up value. When a committed PC equals a descriptor's trigger address, that descriptor counts a match. Every Nth match is a qualifying event. After a programmed number of qualifying events has been skipped, each further qualifying event fires a prefetch.

A fired prefetch waits in a one-bit pending slot of its descriptor. One pending descriptor per cycle, the lowest-numbered first, is turned into a 32-byte-aligned line request. The request goes into a short request queue, which presents line requests to the memory system with a valid/ready handshake. The processor is never stalled. When the queue is full, firings are dropped and counted. A request for the same line as the one enqueued just before it is folded into that earlier request.

Top module: `pc_stride_prefetcher`

## Requirements
- R1: A fill writes a descriptor into the entry that already has the same trigger address and the same stride. If there is no such entry, it goes into the lowest-numbered empty entry. The write resets that entry's match and warm-up progress. `table_full` is 1 exactly when all 8 entries are in use. Entries are never emptied except by reset.
- R2: A fill that finds no matching entry and no empty entry is discarded, and `fill_overflow` is set. `fill_overflow` stays set until reset.
- R3: Take an entry with divider 1 and warm-up 0, and a queue that is empty. If `pc_valid` is high with `pc` equal to its trigger in the cycle that ends at clock edge E1, the entry's request becomes visible on `req_valid`/`req_addr` after edge E2, and not after E1.
- R4: With divider N ≥ 1, only every Nth trigger match is a qualifying event. A divider of 0 behaves like 1.
- R5: With warm-up value S, the first S qualifying events after a fill fire nothing. Every qualifying event after them fires.
- R6: After each prefetch that is enqueued or merged, the entry's prefetch address advances by the signed two's-complement stride. Negative strides and strides that are not powers of two work.
- R7: `req_addr` is always the prefetch address with its low 5 bits cleared (32-byte lines).
- R8: If a firing maps to the same line as the request enqueued most recently since reset, no new request is enqueued. The entry's address still advances.
- R9: If several entries fire on the same PC, their requests are enqueued one per cycle in ascending entry order.
- R10: The request queue holds 4 requests and delivers them in order. A request shown while `req_ready` is low stays valid with the same address.
- R11: If a firing is served while the queue holds 4 requests, the firing is dropped. The entry's address does not advance. `drop_count` increases by one and stops at its maximum value.
- R12: After reset, `req_valid`, `table_full`, `fill_overflow` and `drop_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Write a descriptor this cycle |
| fill_trigger | input | 32 | Instruction address that triggers the descriptor |
| fill_base | input | 32 | First prefetch address |
| fill_stride | input | 32 | Signed step added after each prefetch |
| fill_count | input | 8 | Divider: every Nth match qualifies |
| fill_start | input | 8 | Number of qualifying events to skip |
| pc_valid | input | 1 | A committed instruction address is present |
| pc | input | 32 | Committed instruction address |
| req_ready | input | 1 | Memory system accepts the current request |
| req_valid | output | 1 | A line request is presented |
| req_addr | output | 32 | Line-aligned request address |
| table_full | output | 1 | All descriptor entries are in use |
| fill_overflow | output | 1 | Sticky: a fill was discarded |
| drop_count | output | 8 | Saturating count of firings dropped on a full queue |

## Verification
Most faults in the internal state show up at the request port. A wrong match counter or warm-up counter shows as a missing or extra request within two cycles of the triggering PC. A stride or merge fault shows as a wrong line address or a wrong number of handshakes over a run of triggers. A queue pointer fault shows as reordered or repeated addresses once a backlog drains. A fault in the advance-on-drop rule stays hidden until the next request from the same entry, which then carries the wrong address. Faults in allocation show as a stale base on the next trigger, or as an early or missing `table_full` and `fill_overflow`.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int LINE_B = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // clear the offset-within-line bits
  function automatic addr_t line_of(input addr_t a);
    return a & ~addr_t'(LINE_B - 1);
  endfunction

  // two's-complement step, wraps modulo 2^ADDR_W
  function automatic addr_t step(input addr_t a, input addr_t stride);
    return a + stride;
  endfunction

  // match number (m+1) completes a group of c; c of 0 acts as 1
  function automatic logic completes_group(input cnt_t m, input cnt_t c);
    return ({1'b0, m} + 1'b1) >= {1'b0, c};
  endfunction
endpackage

// File: rtl/pfx_entry.sv
module pfx_entry
  import pfx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t f_trig,
  input  addr_t f_base,
  input  addr_t f_stride,
  input  cnt_t  f_count,
  input  cnt_t  f_start,
  input  logic  pc_valid,
  input  addr_t pc,
  input  logic  serve,
  input  logic  advance,
  output logic  valid,
  output logic  pend,
  output addr_t trig,
  output addr_t stride,
  output addr_t base
);
  cnt_t count, warm_left, match_ctr;
  logic hit, qual, fire;

  assign hit  = valid && pc_valid && (pc == trig);
  assign qual = hit && completes_group(match_ctr, count);
  assign fire = qual && (warm_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      pend      <= 1'b0;
      trig      <= '0;
      base      <= '0;
      stride    <= '0;
      count     <= '0;
      warm_left <= '0;
      match_ctr <= '0;
    end else if (wr) begin
      valid     <= 1'b1;
      pend      <= 1'b0;
      trig      <= f_trig;
      base      <= f_base;
      stride    <= f_stride;
      count     <= f_count;
      warm_left <= f_start;
      match_ctr <= '0;
    end else begin
      if (hit) match_ctr <= qual ? '0 : match_ctr + 1'b1;
      if (qual && warm_left != '0) warm_left <= warm_left - 1'b1;
      if (advance) base <= step(base, stride);
      if (serve) pend <= 1'b0;
      if (fire) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pfx_queue.sv
module pfx_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill_lvl;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (fill_lvl != '0);
  assign full      = (fill_lvl == CW'(DEPTH));
  assign dout      = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      fill_lvl <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      fill_lvl <= fill_lvl + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/pc_stride_prefetcher.sv
module pc_stride_prefetcher
  import pfx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int QDEPTH  = 4,
  parameter int DROP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [31:0]       fill_trigger,
  input  logic [31:0]       fill_base,
  input  logic [31:0]       fill_stride,
  input  logic [7:0]        fill_count,
  input  logic [7:0]        fill_start,
  input  logic              pc_valid,
  input  logic [31:0]       pc,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [31:0]       req_addr,
  output logic              table_full,
  output logic              fill_overflow,
  output logic [DROP_W-1:0] drop_count
);
  logic [ENTRIES-1:0] e_valid, e_pend, key_hit, fill_wr, sel_oh, adv;
  addr_t e_trig [ENTRIES];
  addr_t e_stride [ENTRIES];
  addr_t e_base [ENTRIES];

  // fill placement: same trigger+stride, else lowest empty, else discard
  logic fill_drop;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      key_hit[i] = e_valid[i] && e_trig[i] == fill_trigger && e_stride[i] == fill_stride;
    fill_drop = 1'b0;
    if (|key_hit)        fill_wr = key_hit & (~key_hit + 1'b1);
    else if (~&e_valid)  fill_wr = ~e_valid & (e_valid + 1'b1);
    else begin
      fill_wr   = '0;
      fill_drop = fill_valid;
    end
    fill_wr = fill_wr & {ENTRIES{fill_valid}};
  end

  // service: lowest pending entry
  logic  sel_valid, q_merge, q_push, q_drop, q_full, q_pop;
  addr_t sel_base, sel_line, last_line;
  logic  last_valid;

  assign sel_oh    = e_pend & (~e_pend + 1'b1);
  assign sel_valid = |e_pend;
  always_comb begin
    sel_base = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (sel_oh[i]) sel_base = sel_base | e_base[i];
  end
  assign sel_line = line_of(sel_base);
  assign q_merge  = sel_valid && last_valid && (sel_line == last_line);
  assign q_push   = sel_valid && !q_merge && !q_full;
  assign q_drop   = sel_valid && !q_merge && q_full;
  assign adv      = sel_oh & {ENTRIES{q_push | q_merge}};
  assign q_pop    = req_valid && req_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    pfx_entry u_ent (
      .clk(clk), .rst_n(rst_n), .wr(fill_wr[g]),
      .f_trig(fill_trigger), .f_base(fill_base), .f_stride(fill_stride),
      .f_count(fill_count), .f_start(fill_start),
      .pc_valid(pc_valid), .pc(pc),
      .serve(sel_oh[g]), .advance(adv[g]),
      .valid(e_valid[g]), .pend(e_pend[g]),
      .trig(e_trig[g]), .stride(e_stride[g]), .base(e_base[g])
    );
  end

  pfx_queue #(.DEPTH(QDEPTH), .W(ADDR_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(sel_line), .pop(q_pop),
    .out_valid(req_valid), .dout(req_addr), .full(q_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_valid    <= 1'b0;
      last_line     <= '0;
      drop_count    <= '0;
      fill_overflow <= 1'b0;
    end else begin
      if (q_push) begin
        last_valid <= 1'b1;
        last_line  <= sel_line;
      end
      if (q_drop && drop_count != '1) drop_count <= drop_count + 1'b1;
      if (fill_drop) fill_overflow <= 1'b1;
    end
  end

  assign table_full = &e_valid;
endmodule

// File: rtl/pfx_chk.sv
module pfx_chk #(
  parameter int ENTRIES = 8,
  parameter int DROP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_addr,
  input logic              table_full,
  input logic              fill_overflow,
  input logic [DROP_W-1:0] drop_count,
  input logic              push,
  input logic              drop,
  input logic              merge,
  input logic [ENTRIES-1:0] serve
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R10
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> req_valid);
  // R7
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[4:0] == 5'd0);
  // R11
  drop_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (drop_count == $past(drop_count) + 1'b1) || ($past(drop_count) == '1));
  // R11
  drop_no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> drop_count == $past(drop_count));
  // R2
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_overflow |=> fill_overflow);
  // R1
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_full |=> table_full);
  // R9
  one_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(serve));
  // R8
  merge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push, drop, merge}) <= 1);
endmodule

bind pc_stride_prefetcher pfx_chk #(.ENTRIES(ENTRIES), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .table_full(table_full), .fill_overflow(fill_overflow),
  .drop_count(drop_count), .push(q_push), .drop(q_drop), .merge(q_merge),
  .serve(sel_oh)
);

// File: tb/pc_stride_prefetcher_test.sv
`timescale 1ns/1ps
module pc_stride_prefetcher_test;
  logic        clk = 0, rst_n = 0;
  logic        fill_valid = 0, pc_valid = 0, req_ready = 0;
  logic [31:0] fill_trigger = 0, fill_base = 0, fill_stride = 0, pc = 0;
  logic [7:0]  fill_count = 0, fill_start = 0;
  logic        req_valid, table_full, fill_overflow;
  logic [31:0] req_addr;
  logic [7:0]  drop_count;

  pc_stride_prefetcher uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, ngot = 0;
  logic [31:0] got [32];

  always @(negedge clk)
    if (rst_n && req_valid && req_ready) begin
      if (ngot < 32) got[ngot] = req_addr;
      ngot++;
    end

  // vectors: one entry triggered by PC 0x100, ready always high, 3 idle cycles between triggers
  localparam logic [31:0] V_BASE [6] = '{32'h1000, 32'h2000, 32'h3000, 32'h4004, 32'h5000, 32'h6000};
  localparam logic [31:0] V_STR  [6] = '{32'h40, 32'h190, 32'hFFFF_FFE0, 32'h4, 32'h20, 32'h100};
  localparam logic [7:0]  V_CNT  [6] = '{8'd1, 8'd2, 8'd1, 8'd1, 8'd3, 8'd0};
  localparam logic [7:0]  V_STA  [6] = '{8'd0, 8'd0, 8'd2, 8'd0, 8'd1, 8'd0};
  localparam int          V_NPC  [6] = '{3, 5, 5, 10, 9, 2};
  localparam int          V_N    [6] = '{3, 2, 3, 2, 2, 2};
  localparam logic [31:0] V_LAST [6] = '{32'h1080, 32'h2180, 32'h2FC0, 32'h4020, 32'h5020, 32'h6100};
  localparam string       V_REQ  [6] = '{"R6", "R4", "R5", "R8", "R5", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; fill_valid = 0; pc_valid = 0; req_ready = 0;
    tick(2);
    rst_n = 1;
    ngot = 0;
  endtask

  task automatic fill(input logic [31:0] trg, input logic [31:0] b, input logic [31:0] s,
                      input logic [7:0] c, input logic [7:0] st);
    fill_valid = 1; fill_trigger = trg; fill_base = b; fill_stride = s;
    fill_count = c; fill_start = st;
    tick(1);
    fill_valid = 0;
  endtask

  task automatic pulse(input logic [31:0] a);
    pc_valid = 1; pc = a;
    tick(1);
    pc_valid = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R12 reset state
    do_reset();
    @(negedge clk);
    chk("R12 req_valid", 32'(req_valid), 0);
    chk("R12 table_full", 32'(table_full), 0);
    chk("R12 fill_overflow", 32'(fill_overflow), 0);
    chk("R12 drop_count", 32'(drop_count), 0);
    tick(1);

    // vector walk
    for (int v = 0; v < 6; v++) begin
      do_reset();
      fill(32'h100, V_BASE[v], V_STR[v], V_CNT[v], V_STA[v]);
      req_ready = 1;
      for (int k = 0; k < V_NPC[v]; k++) begin
        pulse(32'h100);
        tick(3);
      end
      tick(6);
      chk({V_REQ[v], " count"}, 32'(ngot), 32'(V_N[v]));
      chk({V_REQ[v], " last"}, (ngot > 0) ? got[ngot-1] : 32'hDEAD_BEEF, V_LAST[v]);
    end

    // R3 latency: visible after the second edge, not the first
    do_reset();
    fill(32'h140, 32'h7010, 32'h40, 8'd1, 8'd0);
    pulse(32'h140);
    @(negedge clk);
    chk("R3 not yet", 32'(req_valid), 0);
    @(negedge clk);
    chk("R3 valid", 32'(req_valid), 1);
    chk("R7 addr", req_addr, 32'h7000);
    tick(1);

    // R1/R2 allocation and overflow
    do_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 not full yet", 32'(table_full), 0);
      tick(1);
      fill(32'h100 + 32'(i) * 4, 32'hC000 + 32'(i) * 32'h1000, 32'h40, 8'd1, 8'd0);
    end
    @(negedge clk);
    chk("R1 full", 32'(table_full), 1);
    chk("R2 no overflow yet", 32'(fill_overflow), 0);
    tick(1);
    fill(32'h900, 32'hE000, 32'h40, 8'd1, 8'd0);
    @(negedge clk);
    chk("R2 overflow", 32'(fill_overflow), 1);
    tick(1);
    fill(32'h100, 32'hD500, 32'h40, 8'd1, 8'd0);
    req_ready = 1;
    pulse(32'h100);
    tick(5);
    chk("R1 overwrite count", 32'(ngot), 1);
    chk("R1 overwrite base", got[0], 32'hD500);
    pulse(32'h900);
    tick(5);
    chk("R2 dropped fill inert", 32'(ngot), 1);
    chk("R2 overflow held", 32'(fill_overflow), 1);

    // R9 several entries on one PC
    do_reset();
    fill(32'h200, 32'h8000, 32'h40, 8'd1, 8'd0);
    fill(32'h200, 32'h9000, 32'h80, 8'd1, 8'd0);
    fill(32'h200, 32'hA000, 32'h20, 8'd1, 8'd0);
    req_ready = 1;
    pulse(32'h200);
    tick(8);
    chk("R9 count", 32'(ngot), 3);
    chk("R9 first", got[0], 32'h8000);
    chk("R9 second", got[1], 32'h9000);
    chk("R9 third", got[2], 32'hA000);

    // R10/R11 full queue
    do_reset();
    fill(32'h300, 32'hB000, 32'h40, 8'd1, 8'd0);
    for (int k = 0; k < 6; k++) pulse(32'h300);
    tick(4);
    chk("R11 drops", 32'(drop_count), 2);
    chk("R10 head valid", 32'(req_valid), 1);
    chk("R10 head addr", req_addr, 32'hB000);
    tick(2);
    chk("R10 head held", req_addr, 32'hB000);
    req_ready = 1;
    tick(8);
    chk("R10 drained", 32'(ngot), 4);
    chk("R10 order first", got[0], 32'hB000);
    chk("R10 order last", got[3], 32'hB0C0);
    pulse(32'h300);
    tick(5);
    chk("R11 base kept", got[4], 32'hB100);
    req_ready = 0;
    pc_valid = 1; pc = 32'h300;
    tick(300);
    pc_valid = 0;
    tick(2);
    chk("R11 saturate", 32'(drop_count), 255);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule